// File: doc/BRIEF.md
# Burst Address Counter Register

This block is the address stage that sits in front of one port of a synchronous memory array. At every rising clock edge it chooses the internal address the array will use for the next access. It can take a fresh address from the external bus, step its own count up by one, keep its current value, or return to zero. Three active-low controls choose the action, and all of them are sampled on the clock edge. The internal address is held in a single register, so the four actions share one piece of storage.

A burst works like this. The caller presents a start address with the strobe low. It then raises the strobe and pulls the count enable low, and each following access goes to the next location. If the strobe is held low on every cycle, each access gets its own external address and the access pattern can be fully random. The clear and the step both take effect at the edge where they are sampled, so the access in that cycle already uses the new address and no idle cycle is needed. An asynchronous active-low reset, released through a synchronizer, puts the register into a known state.

Top module: `burst_addr_reg`

## Requirements
- R1: While the reset input is low, the internal address reads zero. It stays zero until an action is sampled after reset has been released.
- R2: With the counter clear high and the strobe low, the external address is captured at the rising edge and is then the internal address.
- R3: With the counter clear high, the strobe high and the count enable low, the internal address goes up by one at each rising edge.
- R4: With the counter clear, the strobe and the count enable all high, the internal address keeps its value across edges.
- R5: With the counter clear low, the internal address becomes zero at the edge. The strobe, the count enable and the external bus have no effect in that cycle.
- R6: With the strobe low and the count enable also low, the captured value is the external address itself and not that value plus one.
- R7: A step from the all-ones address gives zero.
- R8: Holding the strobe low on consecutive edges gives each of those cycles its own, unrelated external address.
- R9: A step sampled at the edge right after a clear gives address 1, with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ext_addr_i | input | AW | External address bus |
| ads_n_i | input | 1 | Address strobe, active low: load the external address |
| cnt_en_n_i | input | 1 | Count enable, active low: step the count |
| cnt_rst_n_i | input | 1 | Counter clear, active low: force the address to zero |
| addr_o | output | AW | Internal address used by the array |

## Verification
Two cases are the hardest to reach. One is the wrap from all ones to zero. The other is a clear sampled in the same edge as a strobe load, with the next edge stepping straight on from zero. A counter that is only ever stepped upward from small values never gets to all ones, so the stimulus loads 16'hFFFF directly and then steps once. For the priority and no-dead-cycle cases, the stimulus asserts the clear together with a strobe carrying a nonzero address and an active count enable. The very next cycle is a step, and it must give address 1.

// File: rtl/bac_pkg.sv
package bac_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_STEP = 2'd1,
    OP_LOAD = 2'd2,
    OP_CLR  = 2'd3
  } bac_op_e;
endpackage

// File: rtl/bac_rst_sync.sv
module bac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/bac_decode.sv
module bac_decode
  import bac_pkg::*;
(
  input  logic    ads_n,
  input  logic    cnt_en_n,
  input  logic    cnt_rst_n,
  output bac_op_e op
);
  // clear outranks load, load outranks step, step outranks hold
  always_comb begin
    if (!cnt_rst_n)     op = OP_CLR;
    else if (!ads_n)    op = OP_LOAD;
    else if (!cnt_en_n) op = OP_STEP;
    else                op = OP_HOLD;
  end
endmodule

// File: rtl/bac_next.sv
module bac_next
  import bac_pkg::*;
#(
  parameter int AW = 16
) (
  input  bac_op_e       op,
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] ext,
  output logic [AW-1:0] nxt,
  output logic          upd
);
  localparam logic [AW-1:0] ONE = AW'(1);

  always_comb begin
    nxt = cur;
    upd = 1'b1;
    unique case (op)
      OP_CLR:  nxt = '0;
      OP_LOAD: nxt = ext;
      OP_STEP: nxt = cur + ONE;
      default: upd = 1'b0;
    endcase
  end
endmodule

// File: rtl/burst_addr_reg.sv
module burst_addr_reg
  import bac_pkg::*;
#(
  parameter int AW = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ext_addr_i,
  input  logic          ads_n_i,
  input  logic          cnt_en_n_i,
  input  logic          cnt_rst_n_i,
  output logic [AW-1:0] addr_o
);
  logic          rst_q_n;
  bac_op_e       op;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_d;
  logic          addr_en;
  logic          armed_q;

  bac_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  bac_decode u_dec (
    .ads_n     (ads_n_i),
    .cnt_en_n  (cnt_en_n_i),
    .cnt_rst_n (cnt_rst_n_i),
    .op        (op)
  );

  bac_next #(.AW(AW)) u_next (
    .op  (op),
    .cur (addr_q),
    .ext (ext_addr_i),
    .nxt (addr_d),
    .upd (addr_en)
  );

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)     addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) armed_q <= 1'b0;
    else          armed_q <= 1'b1;
  end

  assign addr_o = addr_q;

  // R5
  clr_zero_chk: assert property (@(posedge clk) disable iff (!armed_q)
    $past(!cnt_rst_n_i) |-> addr_o == '0);
  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!armed_q)
    $past(cnt_rst_n_i && !ads_n_i) |-> addr_o == $past(ext_addr_i));
  // R3
  step_inc_chk: assert property (@(posedge clk) disable iff (!armed_q)
    $past(cnt_rst_n_i && ads_n_i && !cnt_en_n_i) |-> addr_o == AW'($past(addr_o) + AW'(1)));
  // R4
  hold_keep_chk: assert property (@(posedge clk) disable iff (!armed_q)
    $past(cnt_rst_n_i && ads_n_i && cnt_en_n_i) |-> $stable(addr_o));
endmodule

// File: tb/test_burst_addr_reg.sv
module test_burst_addr_reg;
  localparam int AW = 16;
  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] ext;
  logic ads_n, en_n, crst_n;
  logic [AW-1:0] addr;

  logic [AW-1:0] exp_q[$];
  string         tag_q[$];
  logic [AW-1:0] model;
  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  burst_addr_reg #(.AW(AW)) i_burst_addr_reg (
    .clk(clk), .rst_n(rst_n), .ext_addr_i(ext), .ads_n_i(ads_n),
    .cnt_en_n_i(en_n), .cnt_rst_n_i(crst_n), .addr_o(addr)
  );

  task automatic check(input logic [AW-1:0] act, input logic [AW-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: addr actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic a, input logic e,
                       input logic [AW-1:0] x, input string tag);
    @(negedge clk);
    crst_n = c; ads_n = a; en_n = e; ext = x;
    if (!c)      model = '0;
    else if (!a) model = x;
    else if (!e) model = model + AW'(1);
    exp_q.push_back(model);
    tag_q.push_back(tag);
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) check(addr, exp_q.pop_front(), tag_q.pop_front());
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ext = 16'h9999; ads_n = 1'b0; en_n = 1'b0; crst_n = 1'b1;
    model = '0;
    repeat (3) @(negedge clk);
    check(addr, '0, "R1 reset value");
    rst_n = 1'b1; ads_n = 1'b1; en_n = 1'b1;
    repeat (4) @(negedge clk);
    check(addr, '0, "R1 after release");

    drive(1, 0, 1, 16'h1234, "R2 load");
    drive(1, 1, 0, 16'h0000, "R3 step1");
    drive(1, 1, 0, 16'hFFFF, "R3 step2");
    drive(1, 1, 0, 16'h0F0F, "R3 step3");
    drive(1, 1, 1, 16'hAAAA, "R4 hold1");
    drive(1, 1, 1, 16'h5555, "R4 hold2");
    drive(1, 0, 0, 16'h00AA, "R6 load beats step");
    drive(0, 0, 0, 16'h5555, "R5 clear beats load");
    drive(1, 1, 0, 16'h7777, "R9 step after clear");
    drive(0, 1, 1, 16'h0000, "R5 clear from hold");
    drive(1, 0, 1, 16'hFFFF, "R7 load all ones");
    drive(1, 1, 0, 16'h0000, "R7 wrap");
    drive(1, 1, 0, 16'h0000, "R7 after wrap");
    drive(1, 0, 1, 16'h8001, "R8 random a");
    drive(1, 0, 1, 16'h0042, "R8 random b");
    drive(1, 0, 0, 16'hC3C3, "R8 random c");
    drive(1, 0, 1, 16'h0007, "R8 random d");
    drive(1, 1, 1, 16'h0000, "R4 idle");
    repeat (3) @(negedge clk);

    rst_n = 1'b0;
    #1;
    check(addr, '0, "R1 async reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(addr, '0, "R1 hold after reset");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule